// File: doc/BRIEF.md
# Marker-Bit UART Frame Transmitter

This block serialises one byte at a time into an asynchronous frame: a low start bit, eight data bits least significant first, then a high stop level. The host writes a byte with a one-cycle strobe. From then on the block runs by itself, and it raises a sticky completion flag when the last data bit has gone out. The host must clear that flag with a separate strobe.

Bit timing comes from a free-running divide-by-16 counter. The counter advances on every pulse of a 16x baud tick. Each wrap of the counter marks one bit time. A frame does not begin at the moment of the write: it waits for the next wrap, so every bit edge of the frame lines up with the shared counter.

The end of the data is detected by a 9-bit shift register, which makes a bit counter unnecessary. At load time a '1' marker sits above the byte. Each shift moves the register right and pulls in a zero at the top. The frame is over when the marker has reached bit 1 and every bit above it is zero.

The controller is a four-state machine:
- `TX_IDLE`: the line is high. A write moves the machine to `TX_ARMED` (transition *accept*).
- `TX_ARMED`: the line stays high until the next wrap. At that wrap the machine moves to `TX_START` (transition *launch*).
- `TX_START`: the start bit is driven. At the next wrap the machine moves to `TX_DATA` (transition *open*).
- `TX_DATA`: the register's bit 0 is driven on the line. Each wrap shifts the register (transition *shift*). At the wrap where the marker pattern is present, the machine makes the final shift, sets the flag and returns to `TX_IDLE` (transition *finish*).

Top module: `uart_marker_tx`

## Requirements
- R1: A divide-by-16 counter resets to 0. It advances by one on each cycle where `tick16` is high and wraps from 15 to 0. A wrap is a cycle where `tick16` is high while the count is 15. One bit time is the span between two wraps.
- R2: A `wr_en` pulse while idle loads `wr_data` with a '1' marker in bit 8 of the shift register. `txd` stays 1 until the first wrap strictly after the write cycle. A wrap in the write cycle itself does not launch the frame.
- R3: From the first wrap after the write until the second, `txd` is 0 (the start bit).
- R4: After the second wrap, `txd` carries data bit k (k = 0 for the least significant bit) from wrap k+2 until wrap k+3, for k = 0..7.
- R5: The register shifts right with zero fill on each wrap in the data phase. At the 10th wrap after the write the marker sits at bit 1 with zeros above it. On that wrap the last shift is made and `txd` returns to 1.
- R6: `tx_done` goes to 1 on the 10th wrap after the write and stays 1 until it is cleared.
- R7: A `clr_done` pulse makes `tx_done` read 0 on the following cycle. If the clear arrives on the same cycle as the 10th wrap, the set wins and the flag stays 1.
- R8: A `wr_en` pulse while a frame is armed, in its start bit or in its data bits is ignored. The frame in flight keeps its bits and its timing.
- R9: `txd` is 1 while idle. This covers the stop-bit time. A write accepted during the stop-bit time starts its start bit at the next wrap, so the stop level lasts one full bit time.
- R10: After reset, `txd` is 1 and `tx_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | 16x baud tick, one cycle per pulse |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to send |
| clr_done | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial line |
| tx_done | output | 1 | Sticky completion flag |

## Verification
The bench places writes exactly on a wrap cycle. A design that counted that wrap would start the start bit one bit time early. It also fires extra writes in the middle of frames. A design that accepted them would corrupt the remaining data bits or restart the frame. Some writes land in the stop-bit time with no idle gap, and some clears collide with the 10th wrap. These catch a shortened stop level and a clear that wrongly beats the set. The line is also sampled on the cycle just before each wrap, which exposes a divider that wraps at the wrong count and stretches or shrinks the bit time.

// File: rtl/uart_marker_tx_pkg.sv
package uart_marker_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_START = 2'd2,
        TX_DATA  = 2'd3
    } tx_state_t;
endpackage

// File: rtl/uart_bit_divider.sv
// Free-running divide-by-2**DIV_W counter clocked by the oversampling tick.
module uart_bit_divider #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [DIV_W-1:0] count,
    output logic             wrap
);
    localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    assign wrap = tick && (count == LAST);
endmodule

// File: rtl/uart_marker_shifter.sv
// Shift register with a marker bit above the data; zero fill from the top.
module uart_marker_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W:0]   sreg,
    output logic              out_bit,
    output logic              last
);
    localparam int REG_W = DATA_W + 1;

    logic [REG_W-1:0] load_val;
    logic [REG_W-1:0] next_val;

    assign load_val = {1'b1, din};

    generate
        for (genvar i = 0; i < REG_W; i++) begin : g_cell
            if (i == REG_W - 1) begin : g_top
                always_comb begin
                    if (load)       next_val[i] = load_val[i];
                    else if (shift) next_val[i] = 1'b0;
                    else            next_val[i] = sreg[i];
                end
            end else begin : g_mid
                always_comb begin
                    if (load)       next_val[i] = load_val[i];
                    else if (shift) next_val[i] = sreg[i+1];
                    else            next_val[i] = sreg[i];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) sreg <= '0;
        else        sreg <= next_val;
    end

    assign out_bit = sreg[0];
    // Marker at bit 1 with only zeros above: the data MSB is on the line.
    assign last    = sreg[1] && (sreg[REG_W-1:2] == '0);
endmodule

// File: rtl/uart_tx_ctrl.sv
// Frame sequencer: waits for a wrap, then start bit, then data bits.
module uart_tx_ctrl
    import uart_marker_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wrap,
    input  logic      last,
    input  logic      data_bit,
    output tx_state_t state,
    output logic      load,
    output logic      shift,
    output logic      set_done,
    output logic      line
);
    tx_state_t state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (wr_en) state_nx = TX_ARMED;
            TX_ARMED: if (wrap)  state_nx = TX_START;
            TX_START: if (wrap)  state_nx = TX_DATA;
            TX_DATA:  if (wrap && last) state_nx = TX_IDLE;
            default:  state_nx = TX_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        shift    = 1'b0;
        set_done = 1'b0;
        line     = 1'b1;
        unique case (state)
            TX_IDLE: begin
                load = wr_en;
            end
            TX_ARMED: begin
                line = 1'b1;
            end
            TX_START: begin
                line = 1'b0;
            end
            TX_DATA: begin
                line     = data_bit;
                shift    = wrap;
                set_done = wrap && last;
            end
            default: begin
                line = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/uart_marker_tx.sv
module uart_marker_tx
    import uart_marker_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_done,
    output logic              txd,
    output logic              tx_done
);
    logic [DIV_W-1:0] div_count;
    logic             wrap;
    logic [DATA_W:0]  sreg;
    logic             out_bit;
    logic             last;
    logic             load;
    logic             shift;
    logic             set_done;
    tx_state_t        state;

    uart_bit_divider #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick16),
        .count (div_count),
        .wrap  (wrap)
    );

    uart_marker_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (shift),
        .din     (wr_data),
        .sreg    (sreg),
        .out_bit (out_bit),
        .last    (last)
    );

    uart_tx_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wrap     (wrap),
        .last     (last),
        .data_bit (out_bit),
        .state    (state),
        .load     (load),
        .shift    (shift),
        .set_done (set_done),
        .line     (txd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        tx_done <= 1'b0;
        else if (set_done) tx_done <= 1'b1;
        else if (clr_done) tx_done <= 1'b0;
    end
endmodule

// File: rtl/uart_marker_tx_chk.sv
module uart_marker_tx_chk
    import uart_marker_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick16,
    input logic             clr_done,
    input logic             txd,
    input logic             tx_done,
    input tx_state_t        state,
    input logic [DIV_W-1:0] div_count,
    input logic             wrap,
    input logic [DATA_W:0]  sreg
);
    assert_count_wraps_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && div_count == {DIV_W{1'b1}}) |=> (div_count == '0));

    assert_count_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick16 |=> $stable(div_count));

    assert_armed_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_ARMED) |-> txd);

    assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START) |-> !txd);

    assert_start_to_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_START && wrap) |=> (state == TX_DATA));

    assert_marker_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_DATA) |-> (sreg != '0));

    assert_done_on_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> $past(wrap));

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && !clr_done) |=> tx_done);

    assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_done && !wrap) |=> !tx_done);

    assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !wrap) |=> $stable(sreg));

    assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE) |-> txd);
endmodule

bind uart_marker_tx uart_marker_tx_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .clr_done  (clr_done),
    .txd       (txd),
    .tx_done   (tx_done),
    .state     (state),
    .div_count (div_count),
    .wrap      (wrap),
    .sreg      (sreg)
);

// File: tb/uart_marker_tx_bench.sv
`timescale 1ns/1ps
module uart_marker_tx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_GAP   = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick16;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       clr_done;
    logic       txd;
    logic       tx_done;

    int n_chk  = 0;
    int n_fail = 0;
    int phase  = 0;
    int bcnt   = 0;
    bit exp_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_marker_tx u_uart_marker_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick16   (tick16),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .clr_done (clr_done),
        .txd      (txd),
        .tx_done  (tx_done)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit next_is_wrap();
        return (phase == TICK_GAP - 1) && (bcnt == 15);
    endfunction

    function automatic logic frame_bit(input logic [7:0] d, input int n);
        if (n == 0)  return 1'b1;
        if (n == 1)  return 1'b0;
        if (n >= 10) return 1'b1;
        return d[n-2];
    endfunction

    // One clock: drive inputs, advance bench divider model, settle after edge.
    task automatic step(input logic w, input logic [7:0] d, input logic c, output bit rolled);
        wr_en    = w;
        wr_data  = d;
        clr_done = c;
        tick16   = (phase == TICK_GAP - 1);
        rolled   = tick16 && (bcnt == 15);
        if (tick16) bcnt = (bcnt + 1) % 16;
        phase = (phase + 1) % TICK_GAP;
        @(posedge clk);
        #1;
        wr_en    = 1'b0;
        clr_done = 1'b0;
        tick16   = 1'b0;
    endtask

    task automatic frame(input logic [7:0] d, input bit busy_wr, input bit on_wrap,
                         input int gap, input bit do_clear, input bit clr_at_end);
        bit r;
        int rolls;
        bit w;
        bit c;
        repeat (gap) step(1'b0, 8'h00, 1'b0, r);
        if (on_wrap) begin
            while (!next_is_wrap()) step(1'b0, 8'h00, 1'b0, r);
        end
        step(1'b1, d, 1'b0, r);
        check("R2 line high after write", txd, 1'b1);
        rolls = 0;
        while (rolls < 10) begin
            w = busy_wr && (rolls >= 1) && (rolls <= 8) && ((rolls % 3) == 1);
            c = clr_at_end && (rolls == 9) && next_is_wrap();
            if (next_is_wrap() && rolls >= 1)
                check("R1 bit held until wrap", txd, frame_bit(d, rolls));
            step(w, ~d, c, r);
            if (r) begin
                rolls++;
                if (rolls == 10) exp_done = 1'b1;
                if (rolls == 1)       check("R3 start bit", txd, 1'b0);
                else if (rolls < 10)  check(busy_wr ? "R8 data bit under busy write" : "R4 data bit",
                                            txd, frame_bit(d, rolls));
                else                  check("R5 line high after final shift", txd, 1'b1);
                check(clr_at_end ? "R7 set wins over clear" : "R6 done flag", tx_done, exp_done);
            end
        end
        if (do_clear) begin
            step(1'b0, 8'h00, 1'b1, r);
            exp_done = 1'b0;
            check("R7 clear", tx_done, 1'b0);
            check("R9 idle high", txd, 1'b1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit r;
        void'($urandom(32'd4242));
        rst_n    = 1'b0;
        tick16   = 1'b0;
        wr_en    = 1'b0;
        wr_data  = 8'h00;
        clr_done = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset txd", txd, 1'b1);
        check("R10 reset done", tx_done, 1'b0);
        rst_n = 1'b1;

        // Directed corners.
        frame(8'hA5, 1'b0, 1'b1, 5, 1'b1, 1'b0);
        frame(8'h01, 1'b1, 1'b0, 7, 1'b0, 1'b0);
        repeat (40) step(1'b0, 8'h00, 1'b0, r);
        check("R6 done stays set", tx_done, 1'b1);
        frame(8'h80, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        frame(8'h3C, 1'b1, 1'b1, 0, 1'b1, 1'b0);
        frame(8'hFF, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        frame(8'h00, 1'b0, 1'b0, 2, 1'b1, 1'b0);

        // Random frames.
        for (int i = 0; i < 30; i++) begin
            logic [7:0] d;
            int  gap;
            bit  busy;
            bit  onw;
            bit  clr;
            d    = 8'($urandom);
            gap  = int'($urandom % 40);
            busy = bit'($urandom % 2);
            onw  = ($urandom % 4) == 0;
            clr  = bit'($urandom % 2);
            frame(d, busy, onw, gap, clr, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule